// File: doc/BRIEF.md
# Programmable Interrupt Aggregator

This block gathers single-cycle event strobes from two groups of sources into two sticky status registers. One group covers bus-protocol events and the other covers data-mover events. Each status bit is gated by its own enable bit. The gated bits are ORed together and qualified by a global enable, and the result drives one interrupt pin. Two configuration bits set the pin's active level and choose between level signalling and a fixed-length pulse.

Software uses a small register bus. It reads the status registers and clears bits by writing a 1 to them. It reads and writes both enable masks and the configuration register. An event is recorded even when the global enable is off. Once the pin has been raised, it is held by the pending bits and not by the global enable. Turning the global enable off therefore does not withdraw the pin; only clearing the pending status does.

Top module: `irq_aggregator`

## Requirements
- R1: A 1 on `usb_evt_i[i]` at a clock edge sets bit i of the bus-event status register. That register reads at address 0, zero-extended.
- R2: A 1 on `dma_evt_i[i]` at a clock edge sets bit i of the mover-event status register. That register reads at address 2, zero-extended.
- R3: Writing to address 0 or 2 clears every status bit whose write-data bit is 1 and leaves the others unchanged. If the same cycle also carries an event for a bit, that bit ends up set.
- R4: The enable masks are read/write at address 1 (bus events) and address 3 (mover events). A status bit whose enable bit is 0 never contributes to the pin.
- R5: The configuration register is read/write at address 4. Bit 0 is the global enable, bit 1 selects active-high (1) or active-low (0), and bit 2 selects pulse (1) or level (0) mode. Reset clears all registers, so after reset the pin idles high (active low, level mode, inactive).
- R6: Events that arrive while the global enable is 0 are latched in status but do not activate the pin.
- R7: If the global enable is set while an enabled status bit is pending, the pin goes active at the clock edge that follows the write edge.
- R8: Clearing the global enable while the pin is active leaves it active. The pin goes inactive one edge after the last enabled pending bit is cleared.
- R9: In level mode the pin is active exactly while the internal pending state is held, at the level that bit 1 of the configuration register selects.
- R10: In pulse mode, a 0-to-1 change of the qualified pending state produces an active pulse of exactly `PULSE_CYCLES` clocks.
- R11: A new 0-to-1 change that occurs while a pulse is running neither restarts nor lengthens that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| usb_evt_i | input | USB_W | Bus-protocol event strobes |
| dma_evt_i | input | DMA_W | Data-mover event strobes |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | DATA_W | Register write data |
| bus_rdata_o | output | DATA_W | Register read data (combinational) |
| irq_pin_o | output | 1 | Interrupt pin |

## Verification
Two operations can land on the same status bit in one cycle: a new event and a write-one-to-clear from software. The bench provokes this directly by raising an event on a bit while writing a 1 to that same bit. It also mixes sparse random events with random register writes. The result is judged by reading the status register back: the bit must remain set. The pulse generator has the same kind of overlap. The pending state is dropped and raised again while a pulse is still running, and the count of active pin cycles must remain exactly `PULSE_CYCLES`.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

   typedef enum logic [2:0] {
      REG_USB_STAT = 3'd0,
      REG_USB_EN   = 3'd1,
      REG_DMA_STAT = 3'd2,
      REG_DMA_EN   = 3'd3,
      REG_CFG      = 3'd4
   } reg_sel_e;

   typedef struct packed {
      logic pulse_mode;
      logic act_high;
      logic glb_en;
   } cfg_t;

   localparam int CFG_W = $bits(cfg_t);

endpackage

// File: rtl/irq_evt_bank.sv
module irq_evt_bank #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] evt_i,
   input  logic         wr_stat_i,
   input  logic         wr_en_i,
   input  logic [W-1:0] wdata_i,
   output logic [W-1:0] stat_o,
   output logic [W-1:0] en_o,
   output logic         pend_o
);

   logic [W-1:0] stat_q;
   logic [W-1:0] en_q;
   logic [W-1:0] clr_mask;

   if (W < 1) begin : g_bad_w
      $error("irq_evt_bank: W must be at least 1");
   end

   assign clr_mask = wr_stat_i ? wdata_i : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= '0;
         en_q   <= '0;
      end else begin
         stat_q <= (stat_q & ~clr_mask) | evt_i;
         if (wr_en_i) en_q <= wdata_i;
      end
   end

   assign stat_o = stat_q;
   assign en_o   = en_q;
   assign pend_o = |(stat_q & en_q);

   // R1/R2: every strobed bit is visible on the next cycle, even under a clear (R3)
   assert_evt_latch_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_i != '0) |=> ((stat_q & $past(evt_i)) == $past(evt_i)));

   // R3: cleared bits without a coincident event read back as zero
   assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stat_i |=> ((stat_q & $past(wdata_i) & ~$past(evt_i)) == '0));

   // R4: a mask write is held until the next mask write
   assert_en_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en_i |=> $stable(en_q));

endmodule

// File: rtl/irq_pin_gen.sv
module irq_pin_gen #(
   parameter int PULSE_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pend_i,
   input  logic glb_en_i,
   input  logic act_high_i,
   input  logic pulse_mode_i,
   output logic pin_o
);

   logic lvl_q;
   logic lvl_d;
   logic trig;
   logic pulse_act;
   logic act;

   if (PULSE_CYCLES < 1) begin : g_bad_p
      $error("irq_pin_gen: PULSE_CYCLES must be at least 1");
   end

   // held state: raised only under global enable, kept by pending bits alone
   assign lvl_d = pend_i & (glb_en_i | lvl_q);
   assign trig  = lvl_d & ~lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= 1'b0;
      else        lvl_q <= lvl_d;
   end

   if (PULSE_CYCLES == 1) begin : g_pulse_one
      logic pq;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pq <= 1'b0;
         else        pq <= trig;
      end
      assign pulse_act = pq;
   end else begin : g_pulse_cnt
      localparam int CNT_W = $clog2(PULSE_CYCLES + 1);
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)             cnt_q <= '0;
         else if (cnt_q != '0)   cnt_q <= cnt_q - CNT_W'(1);
         else if (trig)          cnt_q <= CNT_W'(PULSE_CYCLES);
      end
      assign pulse_act = (cnt_q != '0);

      // R11: a running pulse only counts down, a trigger cannot reload it
      assert_no_retrig_R11: assert property (@(posedge clk) disable iff (!rst_n)
         (cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
   end

   assign act   = pulse_mode_i ? pulse_act : lvl_q;
   assign pin_o = act_high_i ? act : ~act;

   // R6: with global enable off the state cannot rise
   assert_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!glb_en_i && !lvl_q) |=> !lvl_q);

   // R8: pending bits keep the state up regardless of the global enable
   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_q && pend_i) |=> lvl_q);

   // R8: no pending bits, state drops on the next edge
   assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !pend_i |=> !lvl_q);

   // R7: enabled and pending raises the state on the next edge
   assert_raise_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (glb_en_i && pend_i) |=> lvl_q);

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
   import irq_agg_pkg::*;
#(
   parameter int USB_W        = 8,
   parameter int DMA_W        = 4,
   parameter int DATA_W       = 16,
   parameter int PULSE_CYCLES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [USB_W-1:0]  usb_evt_i,
   input  logic [DMA_W-1:0]  dma_evt_i,
   input  logic              bus_we_i,
   input  logic [2:0]        bus_addr_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   output logic              irq_pin_o
);

   if (USB_W > DATA_W || DMA_W > DATA_W || CFG_W > DATA_W) begin : g_bad_width
      $error("irq_aggregator: register wider than data bus");
   end

   reg_sel_e   sel;
   cfg_t       cfg_q;
   logic       wr_usb_stat, wr_usb_en, wr_dma_stat, wr_dma_en, wr_cfg;
   logic [USB_W-1:0] usb_stat, usb_en;
   logic [DMA_W-1:0] dma_stat, dma_en;
   logic       usb_pend, dma_pend;

   assign sel         = reg_sel_e'(bus_addr_i);
   assign wr_usb_stat = bus_we_i && (sel == REG_USB_STAT);
   assign wr_usb_en   = bus_we_i && (sel == REG_USB_EN);
   assign wr_dma_stat = bus_we_i && (sel == REG_DMA_STAT);
   assign wr_dma_en   = bus_we_i && (sel == REG_DMA_EN);
   assign wr_cfg      = bus_we_i && (sel == REG_CFG);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cfg_q <= '0;
      else if (wr_cfg) cfg_q <= cfg_t'(bus_wdata_i[CFG_W-1:0]);
   end

   irq_evt_bank #(.W(USB_W)) u_usb_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt_i     (usb_evt_i),
      .wr_stat_i (wr_usb_stat),
      .wr_en_i   (wr_usb_en),
      .wdata_i   (bus_wdata_i[USB_W-1:0]),
      .stat_o    (usb_stat),
      .en_o      (usb_en),
      .pend_o    (usb_pend)
   );

   irq_evt_bank #(.W(DMA_W)) u_dma_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt_i     (dma_evt_i),
      .wr_stat_i (wr_dma_stat),
      .wr_en_i   (wr_dma_en),
      .wdata_i   (bus_wdata_i[DMA_W-1:0]),
      .stat_o    (dma_stat),
      .en_o      (dma_en),
      .pend_o    (dma_pend)
   );

   irq_pin_gen #(.PULSE_CYCLES(PULSE_CYCLES)) u_pin (
      .clk          (clk),
      .rst_n        (rst_n),
      .pend_i       (usb_pend | dma_pend),
      .glb_en_i     (cfg_q.glb_en),
      .act_high_i   (cfg_q.act_high),
      .pulse_mode_i (cfg_q.pulse_mode),
      .pin_o        (irq_pin_o)
   );

   always_comb begin
      bus_rdata_o = '0;
      case (sel)
         REG_USB_STAT: bus_rdata_o[USB_W-1:0] = usb_stat;
         REG_USB_EN:   bus_rdata_o[USB_W-1:0] = usb_en;
         REG_DMA_STAT: bus_rdata_o[DMA_W-1:0] = dma_stat;
         REG_DMA_EN:   bus_rdata_o[DMA_W-1:0] = dma_en;
         REG_CFG:      bus_rdata_o[CFG_W-1:0] = cfg_q;
         default:      bus_rdata_o = '0;
      endcase
   end

   // R5: configuration changes only through a write to its address
   assert_cfg_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_cfg |=> $stable(cfg_q));

endmodule

// File: tb/irq_aggregator_tb.sv
module irq_aggregator_tb;

   localparam int UW = 8;
   localparam int DW = 4;
   localparam int BW = 16;
   localparam int P  = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [UW-1:0] usb_evt = '0;
   logic [DW-1:0] dma_evt = '0;
   logic          we = 1'b0;
   logic [2:0]    addr = '0;
   logic [BW-1:0] wdata = '0;
   logic [BW-1:0] rdata;
   logic          pin;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // reference state derived from the requirements
   logic [UW-1:0] m_us, m_ue;
   logic [DW-1:0] m_ds, m_de;
   logic [2:0]    m_cfg;
   logic          m_lvl;
   int            m_cnt;

   always #10 clk = ~clk;

   irq_aggregator #(.USB_W(UW), .DMA_W(DW), .DATA_W(BW), .PULSE_CYCLES(P)) u_dut (
      .clk (clk), .rst_n (rst_n), .usb_evt_i (usb_evt), .dma_evt_i (dma_evt),
      .bus_we_i (we), .bus_addr_i (addr), .bus_wdata_i (wdata),
      .bus_rdata_o (rdata), .irq_pin_o (pin)
   );

   function automatic logic exp_pin();
      logic a;
      a = m_cfg[2] ? (m_cnt != 0) : m_lvl;
      return m_cfg[1] ? a : ~a;
   endfunction

   function automatic logic [BW-1:0] exp_reg(input logic [2:0] a);
      case (a)
         3'd0: return BW'(m_us);
         3'd1: return BW'(m_ue);
         3'd2: return BW'(m_ds);
         3'd3: return BW'(m_de);
         3'd4: return BW'(m_cfg);
         default: return '0;
      endcase
   endfunction

   task automatic model_step(input logic [UW-1:0] u, input logic [DW-1:0] d,
                             input logic w, input logic [2:0] a, input logic [BW-1:0] wd);
      logic pend, lvl_n;
      pend  = (|(m_us & m_ue)) | (|(m_ds & m_de));
      lvl_n = pend & (m_cfg[0] | m_lvl);
      if (m_cnt != 0)          m_cnt = m_cnt - 1;
      else if (lvl_n && !m_lvl) m_cnt = P;
      m_lvl = lvl_n;
      m_us = (m_us & ~((w && a == 3'd0) ? wd[UW-1:0] : '0)) | u;
      m_ds = (m_ds & ~((w && a == 3'd2) ? wd[DW-1:0] : '0)) | d;
      if (w && a == 3'd1) m_ue = wd[UW-1:0];
      if (w && a == 3'd3) m_de = wd[DW-1:0];
      if (w && a == 3'd4) m_cfg = wd[2:0];
   endtask

   task automatic chk(input string tag, input logic [BW-1:0] act, input logic [BW-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic cyc(input string tag, input logic [UW-1:0] u, input logic [DW-1:0] d,
                      input logic w, input logic [2:0] a, input logic [BW-1:0] wd);
      usb_evt = u; dma_evt = d; we = w; addr = a; wdata = wd;
      @(posedge clk);
      model_step(u, d, w, a, wd);
      #2;
      usb_evt = '0; dma_evt = '0; we = 1'b0;
      chk(tag, BW'(pin), BW'(exp_pin()));
   endtask

   task automatic idle(input string tag);
      cyc(tag, '0, '0, 1'b0, 3'd0, '0);
   endtask

   task automatic wr(input string tag, input logic [2:0] a, input logic [BW-1:0] wd);
      cyc(tag, '0, '0, 1'b1, a, wd);
   endtask

   task automatic rd(input string tag, input logic [2:0] a);
      we = 1'b0; addr = a;
      #1;
      chk(tag, rdata, exp_reg(a));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      int pcount;
      void'($urandom(32'd1234));
      m_us = '0; m_ue = '0; m_ds = '0; m_de = '0; m_cfg = '0; m_lvl = 1'b0; m_cnt = 0;
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      // R5 reset state: pin idles high, registers zero
      chk("R5 reset pin", BW'(pin), BW'(1'b1));
      for (int a = 0; a < 5; a++) rd("R5 reset regs", 3'(a));

      // R6: latched while global off, pin inactive
      wr("R4", 3'd1, 16'h00ff);
      rd("R4 usb enable", 3'd1);
      cyc("R6", 8'h04, '0, 1'b0, 3'd0, '0);
      idle("R6"); idle("R6");
      chk("R6 pin inactive", BW'(pin), BW'(1'b1));
      rd("R1 status", 3'd0);

      // R7: enable with pending -> active one edge after write edge
      wr("R7", 3'd4, 16'h0001);
      chk("R7 not yet", BW'(pin), BW'(1'b1));
      idle("R7");
      chk("R7 asserted", BW'(pin), BW'(1'b0));

      // R8: global off keeps pin, clear releases it
      wr("R8", 3'd4, 16'h0000);
      idle("R8");
      chk("R8 held", BW'(pin), BW'(1'b0));
      wr("R8", 3'd0, 16'h0004);
      idle("R8");
      chk("R8 released", BW'(pin), BW'(1'b1));
      rd("R3 cleared", 3'd0);

      // R3: clear and event on same bit in same cycle
      cyc("R3", 8'h02, '0, 1'b0, 3'd0, '0);
      cyc("R3", 8'h02, '0, 1'b1, 3'd0, 16'h0002);
      rd("R3 event wins", 3'd0);
      chk("R3 bit kept", rdata & 16'h2, 16'h2);
      wr("R3", 3'd0, 16'h00ff);

      // R4: disabled bit does not reach pin
      wr("R4", 3'd1, 16'h0001);
      wr("R4", 3'd4, 16'h0001);
      cyc("R4", 8'h20, '0, 1'b0, 3'd0, '0);
      idle("R4"); idle("R4");
      chk("R4 masked", BW'(pin), BW'(1'b1));
      rd("R1 masked bit latched", 3'd0);
      wr("R3", 3'd0, 16'h00ff);

      // R2 + R9: mover event, active-high polarity
      wr("R4", 3'd3, 16'h0001);
      wr("R9", 3'd4, 16'h0003);
      cyc("R2", '0, 4'h1, 1'b0, 3'd0, '0);
      rd("R2 status", 3'd2);
      idle("R9");
      chk("R9 active high", BW'(pin), BW'(1'b1));
      wr("R9", 3'd2, 16'h000f);
      idle("R9");
      chk("R9 released", BW'(pin), BW'(1'b0));

      // R10: pulse width
      wr("R10", 3'd4, 16'h0007);
      pcount = 0;
      cyc("R10", 8'h01, '0, 1'b0, 3'd0, '0);
      for (int i = 0; i < P + 4; i++) begin
         idle("R10");
         if (pin) pcount++;
      end
      chk("R10 pulse length", BW'(pcount), BW'(P));

      // R11: drop and re-raise while pulse runs
      wr("R11", 3'd0, 16'h00ff);
      idle("R11");
      pcount = 0;
      cyc("R11", 8'h01, '0, 1'b0, 3'd0, '0);
      idle("R11"); if (pin) pcount++;
      wr("R11", 3'd0, 16'h0001); if (pin) pcount++;
      idle("R11"); if (pin) pcount++;
      cyc("R11", 8'h01, '0, 1'b0, 3'd0, '0); if (pin) pcount++;
      for (int i = 0; i < P + 4; i++) begin
         idle("R11");
         if (pin) pcount++;
      end
      chk("R11 no retrigger", BW'(pcount), BW'(P));

      // random phase
      for (int n = 0; n < 4000; n++) begin
         logic [UW-1:0] u;
         logic [DW-1:0] d;
         logic w;
         logic [2:0] a;
         u = (($urandom % 6) == 0) ? UW'($urandom) & UW'($urandom) : '0;
         d = (($urandom % 8) == 0) ? DW'($urandom) : '0;
         w = (($urandom % 3) == 0);
         a = 3'($urandom % 5);
         cyc(m_cfg[2] ? "R10" : "R9", u, d, w, a, BW'($urandom));
         if ((n % 16) == 0) begin
            rd("R1", 3'd0); rd("R4", 3'd1); rd("R2", 3'd2);
            rd("R4", 3'd3); rd("R5", 3'd4);
         end
      end

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", checks, fails);
      $finish;
   end

endmodule